// File: doc/BRIEF.md
# Clock Branch Gate Controller

This block gates one downstream clock branch under register control. Software turns the branch on through an enable bit in a control register, and a second register holds vote bits: one chosen vote bit can also keep the branch alive. The branch runs while either source asks for it. A synchronizer chain stands in for the time a real clock cell needs to start or stop. The block only reports the branch as running once that chain has passed the request through.

The control register reports the branch state live in its four top bits. The top bit is a "clock off" flag that reads 1 until the branch actually runs. The field reads 0000 when the branch runs under direct control, and 0010 when it runs with the hardware-handshake mode bit set. It reads 1000 when the branch is stopped. Software can write the field but the writes are dropped. The gated clock-enable output follows the inverse of the off flag exactly. The status field is also driven on a port of its own.

Top module: `clk_branch_gate`

## Requirements
- R1: After reset, the control register (address 0) reads 0x8000_0000, the vote register (address 1) reads 0, clk_en_o is 0 and stat_o is 1000.
- R2: Setting control bit 0 starts the branch. The off flag (control bit 31) and clk_en_o change on the 4th rising edge after the write edge, not earlier.
- R3: The branch runs when control bit 0 OR vote-register bit VOTE_IDX (bit 3 by default) is 1. Clearing one source while the other stays 1 keeps the branch running without a gap.
- R4: When both enable sources drop to 0, the off flag returns to 1 and clk_en_o returns to 0 on the 4th rising edge after the write edge. Once the effective enable has been steady for the sync delay, clk_en_o equals it.
- R5: Writes to control bits [31:28] are ignored. Those bits always show the live status field, which is the same value as stat_o.
- R6: The status field takes one of three codes: 0000 when running with control bit 1 (handshake mode) at 0, 0010 when running with bit 1 at 1, and 1000 when stopped.
- R7: clk_en_o is 1 exactly when control bit 31 reads 0.
- R8: Vote-register bits other than VOTE_IDX do not enable the branch.
- R9: Control bits [27:0] and vote bits [7:0] read back as written. Any address other than 0 and 1 reads 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 vote |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| clk_en_o | output | 1 | Gated clock enable for the branch |
| stat_o | output | 4 | Live status field |

## Verification
A register write that changes one enable source can land in the same cycle that the synchronizer reports the effect of the other source. The other source then appears to decide the outcome. To provoke this, the bench runs the branch from both the control bit and the vote bit, then clears one source and samples clk_en_o on every cycle of the delay window. Any single-cycle drop counts as a failure. The bench also writes the status bits while the branch is running, so a write and a live status update fall in the same cycle. The field read back must still match the running code.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
   localparam int STAT_W = 4;
   localparam logic [STAT_W-1:0] STAT_ON    = 4'b0000;
   localparam logic [STAT_W-1:0] STAT_ON_HS = 4'b0010;
   localparam logic [STAT_W-1:0] STAT_OFF   = 4'b1000;
   localparam int CTRL_ADDR = 0;
   localparam int VOTE_ADDR = 1;
   localparam int EN_BIT    = 0;
   localparam int HS_BIT    = 1;
endpackage

// File: rtl/cbg_regs.sv
module cbg_regs #(
   parameter int ADDR_W = 2,
   parameter int LOW_W  = 28,
   parameter int VOTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LOW_W-1:0]  wdata,
   output logic [LOW_W-1:0]  ctrl_q,
   output logic [VOTE_W-1:0] vote_q
);
   import cbg_pkg::*;

   logic wr_ctrl, wr_vote;
   assign wr_ctrl = wr && (addr == ADDR_W'(CTRL_ADDR));
   assign wr_vote = wr && (addr == ADDR_W'(VOTE_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         vote_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata;
         if (wr_vote) vote_q <= wdata[VOTE_W-1:0];
      end
   end
endmodule

// File: rtl/cbg_sync.sv
module cbg_sync #(
   parameter int STAGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_single
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= d;
         end
         assign q = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cbg_status.sv
module cbg_status #(
   parameter bit HS_REPORT = 1'b1
) (
   input  logic       run,
   input  logic       hs_mode,
   output logic [3:0] field
);
   import cbg_pkg::*;

   generate
      if (HS_REPORT) begin : g_hs
         always_comb begin
            if (!run)        field = STAT_OFF;
            else if (hs_mode) field = STAT_ON_HS;
            else             field = STAT_ON;
         end
      end else begin : g_plain
         logic hs_unused;
         assign hs_unused = hs_mode;
         assign field = run ? STAT_ON : STAT_OFF;
      end
   endgenerate
endmodule

// File: rtl/clk_branch_gate.sv
module clk_branch_gate #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32,
   parameter int VOTE_W      = 8,
   parameter int VOTE_IDX    = 3,
   parameter int SYNC_STAGES = 4,
   parameter bit HS_REPORT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              clk_en_o,
   output logic [3:0]        stat_o
);
   import cbg_pkg::*;

   localparam int LOW_W = DATA_W - STAT_W;

   generate
      if (DATA_W < 8)           begin : g_bad_data  $error("DATA_W too small");      end
      if (VOTE_W > LOW_W)       begin : g_bad_vote  $error("VOTE_W too wide");       end
      if (VOTE_IDX >= VOTE_W)   begin : g_bad_idx   $error("VOTE_IDX out of range"); end
      if (SYNC_STAGES < 1)      begin : g_bad_sync  $error("SYNC_STAGES below 1");   end
      if (ADDR_W < 1)           begin : g_bad_addr  $error("ADDR_W below 1");        end
   endgenerate

   logic [LOW_W-1:0]  ctrl_q;
   logic [VOTE_W-1:0] vote_q;
   logic              eff_en;
   logic              run;
   logic [3:0]        stat_field;
   logic              wdata_top_unused;

   assign wdata_top_unused = ^reg_wdata[DATA_W-1:LOW_W];

   cbg_regs #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .VOTE_W(VOTE_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata[LOW_W-1:0]),
      .ctrl_q (ctrl_q),
      .vote_q (vote_q)
   );

   assign eff_en = ctrl_q[EN_BIT] | vote_q[VOTE_IDX];

   cbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (eff_en),
      .q     (run)
   );

   cbg_status #(.HS_REPORT(HS_REPORT)) u_status (
      .run     (run),
      .hs_mode (ctrl_q[HS_BIT]),
      .field   (stat_field)
   );

   always_comb begin
      if (reg_addr == ADDR_W'(CTRL_ADDR))
         reg_rdata = {stat_field, ctrl_q};
      else if (reg_addr == ADDR_W'(VOTE_ADDR))
         reg_rdata = {{(DATA_W-VOTE_W){1'b0}}, vote_q};
      else
         reg_rdata = '0;
   end

   assign clk_en_o = run;
   assign stat_o   = stat_field;
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              eff_en,
   input logic              clk_en_o,
   input logic [3:0]        stat_o
);
   localparam int CW = $clog2(SYNC_STAGES + 1) + 1;

   logic          eff_q;
   logic [CW-1:0] steady;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q  <= 1'b0;
         steady <= '0;
      end else begin
         eff_q <= eff_en;
         if (eff_en != eff_q)               steady <= '0;
         else if (steady < CW'(SYNC_STAGES)) steady <= steady + 1'b1;
      end
   end

   AST_EN_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o == !stat_o[3]); // R7

   AST_STEADY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_en == eff_q && steady >= CW'(SYNC_STAGES - 1)) |-> (clk_en_o == eff_en)); // R4

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o == 4'b0000 || stat_o == 4'b0010 || stat_o == 4'b1000)); // R6

   AST_TOP_BITS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1 -: 4] == stat_o)); // R5

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > ADDR_W'(1)) |-> (reg_rdata == '0)); // R9
endmodule

bind clk_branch_gate cbg_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .eff_en   (eff_en),
   .clk_en_o (clk_en_o),
   .stat_o   (stat_o)
);

// File: tb/clk_branch_gate_bench.sv
module clk_branch_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        clk_en_o;
   logic [3:0]  stat_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   clk_branch_gate u_clk_branch_gate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o), .stat_o(stat_o)
   );

   // ctrl value, vote value, expected status field (vote bit 3 is the branch vote)
   localparam logic [31:0] T_CTRL [8] = '{32'h1, 32'h3, 32'h0, 32'h2, 32'h0, 32'h1, 32'h0, 32'hF000_0002};
   localparam logic [31:0] T_VOTE [8] = '{32'h0, 32'h0, 32'h8, 32'h8, 32'hF7, 32'h8, 32'h0, 32'h0};
   localparam logic [3:0]  T_EXP  [8] = '{4'b0000, 4'b0010, 4'b0000, 4'b0010, 4'b1000, 4'b0000, 4'b1000, 4'b1000};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_addr = 2'd0;
      #0.5;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 32'h8000_0000);
      rd(2'd1, v); chk("R1 vote", v, 32'h0);
      chk("R1 clk_en", {31'b0, clk_en_o}, 32'h0);
      chk("R1 stat", {28'b0, stat_o}, 32'h8);

      // R2 exact start delay
      wr(2'd0, 32'h1);
      for (int i = 1; i <= 3; i++) begin
         step();
         chk("R2 still off", {31'b0, reg_rdata[31]}, 32'h1);
      end
      step();
      chk("R2 on at edge 4", {31'b0, reg_rdata[31]}, 32'h0);
      chk("R7 en with flag", {31'b0, clk_en_o}, 32'h1);

      // R5 write to top bits while running
      wr(2'd0, 32'h7000_0001);
      rd(2'd0, v); chk("R5 top bits ignored", v, 32'h0000_0001);
      step();
      rd(2'd0, v); chk("R5 field live", v, 32'h0000_0001);

      // R4 exact stop delay
      wr(2'd0, 32'h0);
      for (int i = 1; i <= 3; i++) begin
         step();
         chk("R4 still on", {31'b0, clk_en_o}, 32'h1);
      end
      step();
      chk("R4 off at edge 4", {31'b0, reg_rdata[31]}, 32'h1);
      chk("R7 en off", {31'b0, clk_en_o}, 32'h0);

      // R3 both sources, drop one: no gap
      wr(2'd1, 32'h8);
      wr(2'd0, 32'h1);
      repeat (6) step();
      wr(2'd0, 32'h0);
      for (int i = 0; i < 6; i++) begin
         chk("R3 vote holds branch", {31'b0, clk_en_o}, 32'h1);
         step();
      end
      wr(2'd1, 32'h0);
      repeat (6) step();
      chk("R3 both cleared", {31'b0, clk_en_o}, 32'h0);

      // table of vectors: R6 codes, R8 other votes, R9 readback
      for (int k = 0; k < 8; k++) begin
         wr(2'd0, T_CTRL[k]);
         wr(2'd1, T_VOTE[k]);
         repeat (6) step();
         rd(2'd0, v);
         chk("R6 status field", {28'b0, v[31:28]}, {28'b0, T_EXP[k]});
         chk("R9 ctrl readback", {4'b0, v[27:0]}, {4'b0, T_CTRL[k][27:0]});
         chk("R7 en vs flag", {31'b0, clk_en_o}, {31'b0, ~T_EXP[k][3]});
         rd(2'd1, v);
         chk("R9 vote readback", v, T_VOTE[k] & 32'hFF);
         if (k == 4) chk("R8 other votes ignored", {31'b0, clk_en_o}, 32'h0);
      end

      // R9 unmapped address
      wr(2'd0, 32'h0000_0ABC);
      wr(2'd1, 32'h0000_0055);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      repeat (6) step();
      rd(2'd2, v); chk("R9 addr2 zero", v, 32'h0);
      rd(2'd3, v); chk("R9 addr3 zero", v, 32'h0);
      rd(2'd0, v); chk("R9 ctrl untouched", v, 32'h8000_0ABC);
      rd(2'd1, v); chk("R9 vote untouched", v, 32'h55);
      chk("R9 branch still off", {31'b0, clk_en_o}, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule